// File: doc/BRIEF.md
# Staggered Half-Word Double-Rate Adder

This unit performs 32-bit add, subtract, AND, OR and XOR on a clock that runs at twice the core rate. It splits each operation into two 16-bit halves. The low half is produced one fast cycle after issue. The high half follows one fast cycle later, and it uses the carry that the low half saved in a register. Because the low half of a result is ready so early, the next operation can depend on that result and still be issued in the very next fast cycle. That gives two dependent simple operations per core cycle.

Each issued operation carries two source tags and a destination tag. When a source tag equals the destination tag of the fast operation issued in the cycle just before, the unit forwards that operation's result in place of the port operand. It forwards the low half at issue and the high half one cycle later, so each half arrives exactly when it is needed.

Opcodes outside the fast set are not computed here. They raise a slow-path indication so the scheduler can send them to the longer route, which costs one extra core cycle.

Top module: `dual_rate_alu`

## Requirements
- R1: A fast operation accepted at a clock edge (`in_vld` high, `in_op` 0 to 4) drives `lo_vld` high after that edge, with bits 15:0 of its result on `lo_res`.
- R2: `hi_vld` goes high one fast cycle after `lo_vld` for the same operation, with bits 31:16 of its result on `hi_res`.
- R3: Opcode encoding: 0 is add, 1 is subtract (a minus b, modulo 2^32), 2 is AND, 3 is OR, 4 is XOR.
- R4: A carry out of bit 15 in the low half is added into the high half. For example, 0x0000FFFF + 1 gives 0x00010000.
- R5: If `in_src_a` or `in_src_b` equals the destination tag of the fast operation accepted one cycle earlier, the low half of that operand comes from the earlier result rather than from the port.
- R6: Under the same tag match, the high half of the operand is taken from the earlier operation's high result, so a back-to-back dependent pair computes the full 32-bit value.
- R7: `flag_z` is high when the full 32-bit result is zero. `flag_c` is the carry out of bit 31 for add, is high when no borrow occurs for subtract, and is 0 for logic operations. Both flags are valid together with `hi_vld` and are 0 whenever `hi_vld` is low.
- R8: Opcodes 5 to 7 raise `slow` one cycle after acceptance and produce no `lo_vld` or `hi_vld`. Such an operation never acts as a forwarding source.
- R9: After reset, `lo_vld`, `hi_vld`, `slow`, `flag_z` and `flag_c` are all 0.
- R10: If no fast operation was accepted in the previous cycle, a tag match has no effect and the port operands are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation issue strobe |
| in_op | input | 3 | Opcode |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_src_a | input | 4 | Tag of operand A |
| in_src_b | input | 4 | Tag of operand B |
| in_dst | input | 4 | Destination tag |
| lo_vld | output | 1 | Low half valid |
| lo_res | output | 16 | Low result half |
| hi_vld | output | 1 | High half valid |
| hi_res | output | 16 | High result half |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| slow | output | 1 | Slow-path indication |

## Verification
A wrong saved carry or a lost operand half does not show up on `lo_res`. It shows up only on `hi_res` and the flags, one fast cycle later than the low half. A bad forwarding decision corrupts `lo_res` in the very next cycle, and the error carries on into the high half of the dependent operation. The bench therefore compares both halves and both flags on every cycle against a whole-word reference model. It drives random tags from a small set so that back-to-back dependencies occur often. Directed pairs cover carry propagation, equal-operand subtraction, dependent chains, slow operations and idle gaps.

// File: rtl/dual_rate_alu.sv
module dual_rate_alu #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [TAG_W-1:0] in_src_a,
  input  logic [TAG_W-1:0] in_src_b,
  input  logic [TAG_W-1:0] in_dst,
  output logic             lo_vld,
  output logic [W/2-1:0]   lo_res,
  output logic             hi_vld,
  output logic [W/2-1:0]   hi_res,
  output logic             flag_z,
  output logic             flag_c,
  output logic             slow
);
  localparam int H = W / 2;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  logic             s1_vld;
  logic [2:0]       s1_op;
  logic [TAG_W-1:0] s1_dst;
  logic [H-1:0]     s1_a_hi, s1_b_hi;
  logic             s1_byp_a, s1_byp_b;
  logic             s1_cy;
  logic             s1_lz;

  logic is_fast, take, hit_a, hit_b, is_sub;
  logic [H-1:0] a_lo, b_lo, b_lo_x, lo_n;
  logic [H:0]   sum_lo;

  assign is_fast = in_op <= OP_XOR;
  assign take    = in_vld && is_fast;
  assign hit_a   = s1_vld && (in_src_a == s1_dst);
  assign hit_b   = s1_vld && (in_src_b == s1_dst);
  assign a_lo    = hit_a ? lo_res : in_a[H-1:0];
  assign b_lo    = hit_b ? lo_res : in_b[H-1:0];
  assign is_sub  = in_op == OP_SUB;
  assign b_lo_x  = is_sub ? ~b_lo : b_lo;
  assign sum_lo  = {1'b0, a_lo} + {1'b0, b_lo_x} + {{H{1'b0}}, is_sub};

  always_comb begin
    case (in_op)
      OP_AND:  lo_n = a_lo & b_lo;
      OP_OR:   lo_n = a_lo | b_lo;
      OP_XOR:  lo_n = a_lo ^ b_lo;
      default: lo_n = sum_lo[H-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_op    <= OP_ADD;
      s1_dst   <= '0;
      s1_a_hi  <= '0;
      s1_b_hi  <= '0;
      s1_byp_a <= 1'b0;
      s1_byp_b <= 1'b0;
      s1_cy    <= 1'b0;
      s1_lz    <= 1'b0;
      lo_res   <= '0;
      slow     <= 1'b0;
    end else begin
      s1_vld <= take;
      slow   <= in_vld && !is_fast;
      if (take) begin
        s1_op    <= in_op;
        s1_dst   <= in_dst;
        s1_a_hi  <= in_a[W-1:H];
        s1_b_hi  <= in_b[W-1:H];
        s1_byp_a <= hit_a;
        s1_byp_b <= hit_b;
        s1_cy    <= sum_lo[H];
        s1_lz    <= lo_n == '0;
        lo_res   <= lo_n;
      end
    end
  end

  assign lo_vld = s1_vld;

  logic [H-1:0] a_hi, b_hi, b_hi_x, hi_n;
  logic [H:0]   sum_hi;
  logic         arith;

  assign a_hi   = s1_byp_a ? hi_res : s1_a_hi;
  assign b_hi   = s1_byp_b ? hi_res : s1_b_hi;
  assign b_hi_x = (s1_op == OP_SUB) ? ~b_hi : b_hi;
  assign sum_hi = {1'b0, a_hi} + {1'b0, b_hi_x} + {{H{1'b0}}, s1_cy};
  assign arith  = (s1_op == OP_ADD) || (s1_op == OP_SUB);

  always_comb begin
    case (s1_op)
      OP_AND:  hi_n = a_hi & b_hi;
      OP_OR:   hi_n = a_hi | b_hi;
      OP_XOR:  hi_n = a_hi ^ b_hi;
      default: hi_n = sum_hi[H-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_vld <= 1'b0;
      hi_res <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      hi_vld <= s1_vld;
      flag_z <= s1_vld && s1_lz && (hi_n == '0);
      flag_c <= s1_vld && arith && sum_hi[H];
      if (s1_vld) hi_res <= hi_n;
    end
  end

  // R1
  lo_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op <= OP_XOR) |=> lo_vld);

  // R2
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_vld |=> hi_vld);

  // R8
  slow_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op > OP_XOR) |=> (slow && !lo_vld));

  // R8
  slow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow |=> !hi_vld);

  // R7
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_vld |-> (!flag_z && !flag_c));
endmodule

// File: tb/dual_rate_alu_bench.sv
`timescale 1ns/1ps
module dual_rate_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [3:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic        lo_vld, hi_vld, flag_z, flag_c, slow;
  logic [15:0] lo_res, hi_res;

  always #4 clk = ~clk;

  dual_rate_alu u_dual_rate_alu (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .lo_vld(lo_vld), .lo_res(lo_res), .hi_vld(hi_vld),
    .hi_res(hi_res), .flag_z(flag_z), .flag_c(flag_c), .slow(slow)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          p1_fast = 0, p1_slow = 0, p2_fast = 0;
  logic [31:0] p1_res = '0, p2_res = '0;
  bit          p1_c = 0, p2_c = 0;
  logic [3:0]  p1_dst = '0;
  string       p1_lbl = "", p2_lbl = "";

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_calc(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0: return {1'b0, a} + {1'b0, b};
      3'd1: return {1'b0, a} + {1'b0, ~b} + 33'd1;
      3'd2: return {1'b0, a & b};
      3'd3: return {1'b0, a | b};
      default: return {1'b0, a ^ b};
    endcase
  endfunction

  task automatic check_outputs();
    chk(lo_vld == p1_fast, {"R1 lo_vld ", p1_lbl}, 32'(lo_vld), 32'(p1_fast));
    if (p1_fast)
      chk(lo_res == p1_res[15:0], {"R1 lo_res ", p1_lbl}, 32'(lo_res), 32'(p1_res[15:0]));
    chk(slow == p1_slow, "R8 slow", 32'(slow), 32'(p1_slow));
    chk(hi_vld == p2_fast, {"R2 hi_vld ", p2_lbl}, 32'(hi_vld), 32'(p2_fast));
    if (p2_fast) begin
      chk(hi_res == p2_res[31:16], {"R2 hi_res ", p2_lbl}, 32'(hi_res), 32'(p2_res[31:16]));
      chk(flag_z == (p2_res == 0), {"R7 flag_z ", p2_lbl}, 32'(flag_z), 32'(p2_res == 0));
      chk(flag_c == p2_c, {"R7 flag_c ", p2_lbl}, 32'(flag_c), 32'(p2_c));
    end else begin
      chk(!flag_z && !flag_c, "R7 flags idle", {30'd0, flag_z, flag_c}, 32'd0);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      logic [3:0] sa, logic [3:0] sb, logic [3:0] d, string lbl);
    logic [31:0] ea, eb;
    logic [32:0] r;
    @(negedge clk);
    check_outputs();
    ea = (p1_fast && sa == p1_dst) ? p1_res : a;
    eb = (p1_fast && sb == p1_dst) ? p1_res : b;
    r  = ref_calc(op, ea, eb);
    in_vld = v; in_op = op; in_a = a; in_b = b;
    in_src_a = sa; in_src_b = sb; in_dst = d;
    p2_fast = p1_fast; p2_res = p1_res; p2_c = p1_c; p2_lbl = p1_lbl;
    p1_fast = v && op <= 3'd4;
    p1_slow = v && op > 3'd4;
    p1_res = r[31:0];
    p1_c = (op <= 3'd1) ? r[32] : 1'b0;
    p1_dst = d;
    p1_lbl = lbl;
  endtask

  task automatic idle();
    step(0, 3'd0, 32'd0, 32'd0, 4'd15, 4'd15, 4'd14, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!lo_vld && !hi_vld && !slow && !flag_z && !flag_c, "R9 reset outputs",
        {27'd0, lo_vld, hi_vld, slow, flag_z, flag_c}, 32'd0);
    rst_n = 1'b1;
    idle(); idle();

    // R4 carry from low half into high half
    step(1, 3'd0, 32'h0000FFFF, 32'h00000001, 4'd15, 4'd15, 4'd1, "R4");
    step(1, 3'd0, 32'hFFFFFFFF, 32'h00000001, 4'd15, 4'd15, 4'd2, "R4 wrap");
    idle(); idle();
    // R3 each opcode, R7 sub of equal values
    step(1, 3'd1, 32'h12345678, 32'h12345678, 4'd15, 4'd15, 4'd3, "R3 R7 sub eq");
    step(1, 3'd1, 32'h00010000, 32'h00000001, 4'd14, 4'd14, 4'd3, "R3 borrow");
    step(1, 3'd2, 32'hF0F0FFFF, 32'h0FF0F00F, 4'd13, 4'd13, 4'd4, "R3 and");
    step(1, 3'd3, 32'hA0000001, 32'h05000010, 4'd12, 4'd12, 4'd5, "R3 or");
    step(1, 3'd4, 32'hDEADBEEF, 32'hDEADBEEF, 4'd11, 4'd11, 4'd6, "R3 xor");
    idle(); idle();
    // R5 R6 dependent chain, each uses the previous result
    step(1, 3'd0, 32'h0001FFFF, 32'h0000FFFF, 4'd15, 4'd15, 4'd7, "R5 R6 head");
    step(1, 3'd0, 32'h0, 32'h00008001, 4'd7, 4'd15, 4'd8, "R5 R6 a dep");
    step(1, 3'd1, 32'h00030000, 32'h0, 4'd15, 4'd8, 4'd9, "R5 R6 b dep");
    step(1, 3'd4, 32'h0, 32'h0, 4'd9, 4'd9, 4'd9, "R5 R6 both dep");
    idle(); idle();
    // R8 slow op not a forwarding source
    step(1, 3'd5, 32'h11111111, 32'h22222222, 4'd15, 4'd15, 4'd10, "R8 slow");
    step(1, 3'd0, 32'h00000005, 32'h00000003, 4'd10, 4'd10, 4'd11, "R8 after slow");
    step(1, 3'd7, 32'h0, 32'h0, 4'd11, 4'd11, 4'd12, "R8 slow7");
    idle(); idle();
    // R10 idle gap removes forwarding
    step(1, 3'd0, 32'h00FF00FF, 32'h00010001, 4'd15, 4'd15, 4'd2, "R10 head");
    idle();
    step(1, 3'd0, 32'h00000007, 32'h00000009, 4'd2, 4'd2, 4'd3, "R10 after gap");
    idle(); idle();

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      logic [2:0]  rop;
      ra  = $urandom();
      rb  = $urandom();
      if (($urandom() % 8) == 0) ra[15:0] = 16'hFFFF;
      rop = 3'($urandom() % 6);
      if (rop == 3'd5) rop = 3'($urandom() % 8);
      step(($urandom() % 8) != 0, rop, ra, rb, 4'($urandom() % 4),
           4'($urandom() % 4), 4'($urandom() % 4), "R3 R5 R6 random");
    end
    idle(); idle(); idle();

    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule